// File: doc/BRIEF.md
# Four-Register ADD Instruction Executor

This block is a small execution datapath built around four 16-bit registers. On each clock edge where the instruction strobe is high, it takes one 16-bit instruction word and decodes it. If the opcode selects addition, the block adds two source registers and writes the sum into a destination register. Any other opcode changes nothing.

A separate load port lets surrounding logic or a test fixture set up register contents. A combinational read port lets that logic observe any register at any time. Fetching instructions, sequencing them and handling flags are left to the logic around the block. The caller feeds words in program order, one per accepted cycle.

Each instruction completes at the edge that accepts it. A following instruction in the next cycle therefore already sees the updated register. An instruction may name its own destination as a source, in which case the add uses the value from before the write.

Top module: `add4_exec`

## Requirements
- R1: A synchronous active-high reset clears all four registers to zero at the clock edge where it is sampled high.
- R2: With `ld_en` high and reset low, the register selected by `ld_idx` takes `ld_data` at the clock edge.
- R3: The instruction word is decoded as follows: opcode in bits [15:12], destination index in [11:10], first source index in [9:8], second source index in [7:6].
- R4: With `instr_vld` high, `ld_en` low and opcode 4'b0111, the destination takes (first source + second source) modulo 2^16 at the clock edge.
- R5: When the destination index equals one or both source indices, the sum uses the register values held before that edge.
- R6: An ADD accepted in the cycle directly after another ADD uses the result the earlier one wrote.
- R7: An opcode other than 4'b0111 writes no register.
- R8: Bits [5:0] of the instruction word have no effect on any register.
- R9: With `instr_vld` low, the instruction word writes no register.
- R10: When `ld_en` and `instr_vld` are both high in one cycle, only the load is performed and the instruction is discarded.
- R11: `rd_data` shows the register selected by `rd_idx` combinationally, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all register updates happen on its rising edge |
| rst | input | 1 | Synchronous active-high reset of all registers |
| instr_vld | input | 1 | Instruction word is valid this cycle |
| instr | input | 16 | Packed instruction word |
| ld_en | input | 1 | Load strobe; takes priority over the instruction |
| ld_idx | input | 2 | Register index for the load |
| ld_data | input | 16 | Value to load |
| rd_idx | input | 2 | Register index to observe |
| rd_data | output | 16 | Contents of the register selected by `rd_idx` |

## Verification
Every write, whether from reset, a load or an add, is due at the first rising edge that samples the strobe. The read port has no delay, so a result can be seen right after that edge.

The bench drives inputs on the falling edge and updates its model at the rising edge. At the next falling edge it steps `rd_idx` through all four indices, waiting a short delay at each before comparing. This timing also tests the zero-latency read. The checker uses the same one-edge timing: it compares the value read in the cycle after the strobe with operands and load data captured one edge earlier.

// File: rtl/add4_exec_pkg.sv
package add4_exec_pkg;
   parameter int unsigned DEF_DATA_W  = 16;
   parameter int unsigned DEF_IDX_W   = 2;
   parameter int unsigned DEF_INSTR_W = 16;
   parameter int unsigned DEF_OPC_W   = 4;

   // source of the single register-file write port in a cycle
   typedef enum logic [1:0] {
      WSRC_NONE = 2'd0,
      WSRC_LOAD = 2'd1,
      WSRC_SUM  = 2'd2
   } wsrc_e;
endpackage

// File: rtl/add4_exec_decode.sv
module add4_exec_decode #(
   parameter int unsigned OPC_W   = 4,
   parameter int unsigned IDX_W   = 2,
   parameter logic [OPC_W-1:0] ADD_OPC = 4'b0111,
   localparam int unsigned USED_W = OPC_W + 3 * IDX_W
) (
   input  logic              vld,
   input  logic [USED_W-1:0] fields,
   output logic              is_add,
   output logic [IDX_W-1:0]  dst,
   output logic [IDX_W-1:0]  src_a,
   output logic [IDX_W-1:0]  src_b
);
   logic [OPC_W-1:0] opc;

   // field order from the top: opcode, destination, source a, source b
   assign opc   = fields[USED_W-1 -: OPC_W];
   assign dst   = fields[3*IDX_W-1 -: IDX_W];
   assign src_a = fields[2*IDX_W-1 -: IDX_W];
   assign src_b = fields[IDX_W-1 -: IDX_W];

   assign is_add = vld && (opc == ADD_OPC);
endmodule

// File: rtl/add4_exec_regfile.sv
module add4_exec_regfile #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned IDX_W  = 2,
   localparam int unsigned NREGS = 1 << IDX_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic [IDX_W-1:0]  waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IDX_W-1:0]  ra_a,
   input  logic [IDX_W-1:0]  ra_b,
   input  logic [IDX_W-1:0]  ra_c,
   output logic [DATA_W-1:0] rd_a,
   output logic [DATA_W-1:0] rd_b,
   output logic [DATA_W-1:0] rd_c
);
   logic [DATA_W-1:0] regs [NREGS];

   for (genvar g = 0; g < NREGS; g++) begin : g_entry
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
         if (rst)
            q <= '0;
         else if (we && (waddr == IDX_W'(g)))
            q <= wdata;
      end
      assign regs[g] = q;
   end

   // three independent asynchronous read ports
   assign rd_a = regs[ra_a];
   assign rd_b = regs[ra_b];
   assign rd_c = regs[ra_c];
endmodule

// File: rtl/add4_exec.sv
module add4_exec
   import add4_exec_pkg::*;
#(
   parameter int unsigned DATA_W  = DEF_DATA_W,
   parameter int unsigned IDX_W   = DEF_IDX_W,
   parameter int unsigned INSTR_W = DEF_INSTR_W,
   parameter int unsigned OPC_W   = DEF_OPC_W,
   parameter logic [OPC_W-1:0] ADD_OPC = 4'b0111
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               instr_vld,
   input  logic [INSTR_W-1:0] instr,
   input  logic               ld_en,
   input  logic [IDX_W-1:0]   ld_idx,
   input  logic [DATA_W-1:0]  ld_data,
   input  logic [IDX_W-1:0]   rd_idx,
   output logic [DATA_W-1:0]  rd_data
);
   localparam int unsigned USED_W = OPC_W + 3 * IDX_W;
   localparam int unsigned PAD_W  = INSTR_W - USED_W;

   // elaboration-time parameter checks
   if (USED_W > INSTR_W) begin : g_bad_layout
      $error("add4_exec: instruction fields exceed INSTR_W");
   end
   if (DATA_W < 1 || IDX_W < 1) begin : g_bad_size
      $error("add4_exec: DATA_W and IDX_W must be nonzero");
   end

   // pad bits are never decoded
   if (PAD_W > 0) begin : g_pad
      logic unused_pad;
      assign unused_pad = ^instr[PAD_W-1:0];
   end

   logic              is_add;
   logic [IDX_W-1:0]  dst, src_a, src_b;
   logic [DATA_W-1:0] opnd_a, opnd_b, sum;
   wsrc_e             wsrc;
   logic              we;
   logic [IDX_W-1:0]  waddr;
   logic [DATA_W-1:0] wdata;

   add4_exec_decode #(
      .OPC_W  (OPC_W),
      .IDX_W  (IDX_W),
      .ADD_OPC(ADD_OPC)
   ) u_dec (
      .vld   (instr_vld),
      .fields(instr[INSTR_W-1 -: USED_W]),
      .is_add(is_add),
      .dst   (dst),
      .src_a (src_a),
      .src_b (src_b)
   );

   // wraps modulo 2^DATA_W, carry dropped
   assign sum = opnd_a + opnd_b;

   always_comb begin
      if (ld_en)
         wsrc = WSRC_LOAD;
      else if (is_add)
         wsrc = WSRC_SUM;
      else
         wsrc = WSRC_NONE;
   end

   always_comb begin
      we    = (wsrc != WSRC_NONE);
      waddr = (wsrc == WSRC_LOAD) ? ld_idx  : dst;
      wdata = (wsrc == WSRC_LOAD) ? ld_data : sum;
   end

   add4_exec_regfile #(
      .DATA_W(DATA_W),
      .IDX_W (IDX_W)
   ) u_rf (
      .clk  (clk),
      .rst  (rst),
      .we   (we),
      .waddr(waddr),
      .wdata(wdata),
      .ra_a (src_a),
      .ra_b (src_b),
      .ra_c (rd_idx),
      .rd_a (opnd_a),
      .rd_b (opnd_b),
      .rd_c (rd_data)
   );
endmodule

// File: rtl/add4_exec_chk.sv
module add4_exec_chk #(
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned IDX_W   = 2,
   parameter int unsigned INSTR_W = 16,
   parameter int unsigned OPC_W   = 4,
   parameter logic [OPC_W-1:0] ADD_OPC = 4'b0111
) (
   input logic               clk,
   input logic               rst,
   input logic               instr_vld,
   input logic [INSTR_W-1:0] instr,
   input logic               ld_en,
   input logic [IDX_W-1:0]   ld_idx,
   input logic [DATA_W-1:0]  ld_data,
   input logic [IDX_W-1:0]   rd_idx,
   input logic [DATA_W-1:0]  rd_data,
   input logic [DATA_W-1:0]  opnd_a,
   input logic [DATA_W-1:0]  opnd_b
);
   logic             add_go;
   logic [IDX_W-1:0] dst_f;

   assign add_go = instr_vld && !ld_en && (instr[INSTR_W-1 -: OPC_W] == ADD_OPC);
   assign dst_f  = instr[INSTR_W-OPC_W-1 -: IDX_W];

   AST_RESET_ZERO: assert property (@(posedge clk)
      rst |=> (rd_data == '0)); // R1

   AST_LOAD_LANDS: assert property (@(posedge clk) disable iff (rst)
      ld_en |=> ((rd_idx == $past(ld_idx)) -> (rd_data == $past(ld_data)))); // R10

   AST_SUM_LANDS: assert property (@(posedge clk) disable iff (rst)
      add_go |=> ((rd_idx == $past(dst_f)) -> (rd_data == $past(opnd_a + opnd_b)))); // R4

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (!ld_en && !add_go) |=> ($stable(rd_idx) -> $stable(rd_data))); // R7
endmodule

bind add4_exec add4_exec_chk #(
   .DATA_W (DATA_W),
   .IDX_W  (IDX_W),
   .INSTR_W(INSTR_W),
   .OPC_W  (OPC_W),
   .ADD_OPC(ADD_OPC)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .instr_vld(instr_vld),
   .instr    (instr),
   .ld_en    (ld_en),
   .ld_idx   (ld_idx),
   .ld_data  (ld_data),
   .rd_idx   (rd_idx),
   .rd_data  (rd_data),
   .opnd_a   (opnd_a),
   .opnd_b   (opnd_b)
);

// File: tb/add4_exec_test.sv
module add4_exec_test;
   logic        clk = 1'b0;
   logic        rst = 1'b0;
   logic        instr_vld = 1'b0;
   logic [15:0] instr = '0;
   logic        ld_en = 1'b0;
   logic [1:0]  ld_idx = '0;
   logic [15:0] ld_data = '0;
   logic [1:0]  rd_idx = '0;
   logic [15:0] rd_data;

   int compared = 0;
   int mismatched = 0;
   logic [15:0] mdl [4];

   always #10 clk = ~clk; // 50 MHz

   add4_exec uut (
      .clk(clk), .rst(rst), .instr_vld(instr_vld), .instr(instr),
      .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
      .rd_idx(rd_idx), .rd_data(rd_data)
   );

   function automatic logic [15:0] mk(input logic [3:0] op, input logic [1:0] d,
                                      input logic [1:0] a, input logic [1:0] b,
                                      input logic [5:0] pad);
      return {op, d, a, b, pad};
   endfunction

   // reference update following the requirements
   function automatic void model_edge(input logic r, input logic le, input logic [1:0] li,
                                      input logic [15:0] ldv, input logic v, input logic [15:0] w);
      logic [15:0] s;
      if (r) begin
         for (int i = 0; i < 4; i++) mdl[i] = '0;            // R1
      end else if (le) begin
         mdl[li] = ldv;                                       // R2, R10
      end else if (v && w[15:12] == 4'b0111) begin
         s = mdl[w[9:8]] + mdl[w[7:6]];                       // R3, R4, R5
         mdl[w[11:10]] = s;
      end
   endfunction

   task automatic check_all(input string req);
      for (int i = 0; i < 4; i++) begin
         rd_idx = 2'(i);
         #1;                                                  // R11: no edge needed
         compared++;
         if (rd_data !== mdl[i]) begin
            mismatched++;
            $display("FAIL %s reg%0d actual=%h expected=%h", req, i, rd_data, mdl[i]);
         end
      end
   endtask

   task automatic step(input logic r, input logic le, input logic [1:0] li,
                       input logic [15:0] ldv, input logic v, input logic [15:0] w,
                       input string req);
      rst = r; ld_en = le; ld_idx = li; ld_data = ldv; instr_vld = v; instr = w;
      @(posedge clk);
      model_edge(r, le, li, ldv, v, w);
      @(negedge clk);
      rst = 1'b0; ld_en = 1'b0; instr_vld = 1'b0;
      check_all(req);
   endtask

   initial begin
      #(200000 * 20);
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      logic [3:0] op;
      void'($urandom(32'h5eed_0252));
      for (int i = 0; i < 4; i++) mdl[i] = 'x;
      @(negedge clk);
      step(1'b1, 1'b0, 2'd0, 16'h0, 1'b0, 16'h0, "R1 reset");
      // loads
      step(0, 1, 2'd0, 16'h0003, 0, 16'h0, "R2 load r0");
      step(0, 1, 2'd1, 16'h0005, 0, 16'h0, "R2 load r1");
      step(0, 1, 2'd2, 16'hFFFF, 0, 16'h0, "R2 load r2");
      step(0, 1, 2'd3, 16'h0002, 0, 16'h0, "R2 load r3");
      // r0 = r1 + r0 : destination is a source
      step(0, 0, 2'd0, 16'h0, 1, mk(4'b0111, 2'd0, 2'd1, 2'd0, 6'h00), "R5 dst=src");
      // r2 = r0 + r3 right after: dependency
      step(0, 0, 2'd0, 16'h0, 1, mk(4'b0111, 2'd2, 2'd0, 2'd3, 6'h00), "R6 back-to-back");
      // wrap: r1 = r2 + r2 with large values
      step(0, 1, 2'd2, 16'hFFFF, 0, 16'h0, "R2 load r2");
      step(0, 0, 2'd0, 16'h0, 1, mk(4'b0111, 2'd1, 2'd2, 2'd2, 6'h00), "R4 wrap");
      // field positions: distinct indices
      step(0, 0, 2'd0, 16'h0, 1, mk(4'b0111, 2'd3, 2'd1, 2'd0, 6'h00), "R3 fields");
      // pad bits all ones
      step(0, 0, 2'd0, 16'h0, 1, mk(4'b0111, 2'd0, 2'd3, 2'd1, 6'h3F), "R8 pad ones");
      // non-ADD opcodes
      step(0, 0, 2'd0, 16'h0, 1, mk(4'b0110, 2'd0, 2'd1, 2'd2, 6'h00), "R7 op 0110");
      step(0, 0, 2'd0, 16'h0, 1, mk(4'b1111, 2'd1, 2'd1, 2'd1, 6'h15), "R7 op 1111");
      // valid low
      step(0, 0, 2'd0, 16'h0, 0, mk(4'b0111, 2'd2, 2'd3, 2'd3, 6'h00), "R9 vld low");
      // load and ADD together
      step(0, 1, 2'd1, 16'hABCD, 1, mk(4'b0111, 2'd0, 2'd1, 2'd1, 6'h00), "R10 load wins");
      step(0, 1, 2'd3, 16'h1234, 1, mk(4'b0111, 2'd3, 2'd0, 2'd0, 6'h00), "R10 same dst");
      // reset with load pending
      step(1, 1, 2'd2, 16'h7777, 1, mk(4'b0111, 2'd1, 2'd2, 2'd2, 6'h00), "R1 reset");
      // random mix
      for (int n = 0; n < 400; n++) begin
         op = ($urandom % 2) ? 4'b0111 : 4'($urandom);
         step(($urandom % 64) == 0, ($urandom % 4) == 0, 2'($urandom), 16'($urandom),
              ($urandom % 4) != 0,
              mk(op, 2'($urandom), 2'($urandom), 2'($urandom), 6'($urandom)),
              "R4/R7/R8 random");
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule